// File: doc/BRIEF.md
# Interrupt Controller Poll and Status Read Port

This block is the host-facing command and read path of an eight-level priority interrupt controller. The host writes a command word at the even address. Depending on its bits, that word switches the special mask mode on or off, arms a poll, or picks which internal register later status reads return. A write to the odd address loads the interrupt mask. On a read, the block drives the data bus with one of four values: the poll result, the pending-request bits, the in-service bits, or the mask.

A poll replaces the vectored acknowledge cycle. After the host arms a poll, its next read is treated as the acknowledge. That read returns a byte with two parts: a flag saying whether any eligible request is waiting, and the binary number of the winning level. When a request is waiting, the block sends a one-cycle acknowledge pulse and the level to the priority core, which then sets the matching in-service bit. While a poll is armed, a freeze output tells the core to hold its request state. The status-register selection survives any number of reads. A poll read overrides it for that one read only.

Top module: `pic_host_port`

## Requirements
- R1: After reset the mask is 0x00, special mask mode is off, no poll is armed, and an even-address read returns the request bits.
- R2: A write with `a0`=1 loads `wdata` into the mask. A non-poll read with `a0`=1 returns the mask.
- R3: An even-address write is a command word only when bit 4 is 0 and bit 3 is 1. Any other even-address write changes no mode, selection or poll state.
- R4: In a command word, bit 6 enables a change of special mask mode and bit 5 gives its new value. With bit 6 at 0 the mode is unchanged.
- R5: In a command word with bit 1 set, bit 0 selects the source for even-address reads: 0 selects the request bits, 1 selects the in-service bits. With bit 1 at 0 the selection is unchanged.
- R6: The read selection persists across any number of reads and across mask writes.
- R7: A command word with bit 2 set arms a poll. `poll_freeze` is high from the clock after that write until the clock that ends the next read.
- R8: The first read after a poll is armed returns a poll byte, whatever `a0` is. Bit 7 of the byte is 1 when an eligible request exists, and bits 2..0 hold that request's level. If no request is eligible, the byte is 0x00.
- R9: Level 0 has the highest priority. A level is eligible when its request is set and it is unmasked. In normal mode it must also rank strictly above the highest-priority in-service level. In special mask mode its own in-service bit must be clear instead.
- R10: `poll_ack` pulses for exactly the cycle of a poll read and only when an eligible request exists, with `poll_level` giving the level. At all other times `poll_level` is 0.
- R11: A poll read uses up the armed poll. The next read returns the remembered status selection again.
- R12: `rdata` is 0x00 whenever no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| a0 | input | 1 | Port select: 0 command/status, 1 mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when idle |
| req_bits | input | 8 | Pending request bits from the core |
| svc_bits | input | 8 | In-service bits from the core |
| mask_bits | output | 8 | Current interrupt mask |
| smm_active | output | 1 | Special mask mode on |
| poll_freeze | output | 1 | Poll armed, hold request state |
| poll_ack | output | 1 | Poll acknowledge pulse to the core |
| poll_level | output | 3 | Level being acknowledged |

## Verification
The assertions assume the host never raises `wr` and `rd` in the same cycle, and that each strobe lasts one clock per access. Several properties rely on this: that a poll read clears the freeze, and that a command write sets it. The bench drives every access as a single-cycle strobe with only one of the two strobes active. Between accesses it holds the bus idle and picks new request and in-service patterns from a fixed-seed random source. The core inputs therefore change only while the bus is idle or during a read, never in a way that conflicts with the strobe rules.

// File: rtl/pic_rd_pkg.sv
package pic_rd_pkg;

  // Bit positions inside the command word (the even-address write).
  localparam int CW_ESMM = 6;
  localparam int CW_SMM  = 5;
  localparam int CW_TAG1 = 4;
  localparam int CW_TAG0 = 3;
  localparam int CW_POLL = 2;
  localparam int CW_RR   = 1;
  localparam int CW_RIS  = 0;

  typedef enum logic {
    SEL_REQ = 1'b0,
    SEL_SVC = 1'b1
  } rd_sel_e;

  typedef struct packed {
    logic esmm;
    logic smm;
    logic poll;
    logic rr;
    logic ris;
  } cmd_fields_t;

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_rd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          cs,
  input  logic          wr,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  output logic          mask_wr,
  output logic          cmd_wr,
  output cmd_fields_t   fields
);

  logic wr_act;
  logic tag_ok;

  assign wr_act  = cs & wr;
  assign tag_ok  = (wdata[CW_TAG1] == 1'b0) && (wdata[CW_TAG0] == 1'b1);
  assign mask_wr = wr_act & a0;
  assign cmd_wr  = wr_act & ~a0 & tag_ok;

  always_comb begin
    fields.esmm = wdata[CW_ESMM];
    fields.smm  = wdata[CW_SMM];
    fields.poll = wdata[CW_POLL];
    fields.rr   = wdata[CW_RR];
    fields.ris  = wdata[CW_RIS];
  end

endmodule

// File: rtl/pic_mode_regs.sv
module pic_mode_regs
  import pic_rd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_wr,
  input  logic          cmd_wr,
  input  logic          poll_rd,
  input  cmd_fields_t   fields,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic          smm_q,
  output rd_sel_e       sel_q,
  output logic          armed_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smm_q <= 1'b0;
      sel_q <= SEL_REQ;
    end else if (cmd_wr) begin
      if (fields.esmm) smm_q <= fields.smm;
      if (fields.rr)   sel_q <= fields.ris ? SEL_SVC : SEL_REQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (cmd_wr && fields.poll) begin
      armed_q <= 1'b1;
    end else if (poll_rd) begin
      armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pic_poll_resolve.sv
module pic_poll_resolve #(
  parameter int N     = 8,
  parameter int DW    = 8,
  parameter int LVL_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     svc,
  input  logic             smm,
  output logic             any,
  output logic [LVL_W-1:0] level,
  output logic [DW-1:0]    word
);

  // Levels allowed to win: unmasked requests, limited by in-service state.
  function automatic logic [N-1:0] eligible_set(
    input logic [N-1:0] r,
    input logic [N-1:0] m,
    input logic [N-1:0] s,
    input logic         special
  );
    logic [N-1:0] cand;
    logic [N-1:0] above;
    logic         blocked;
    cand    = r & ~m;
    above   = '0;
    blocked = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (s[i]) blocked = 1'b1;
      above[i] = ~blocked;
    end
    if (special) return cand & ~s;
    return cand & above;
  endfunction

  // Index of the lowest set bit (level 0 ranks highest).
  function automatic logic [LVL_W-1:0] first_set(input logic [N-1:0] v);
    logic [LVL_W-1:0] idx;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) idx = LVL_W'(i);
    end
    return idx;
  endfunction

  logic [N-1:0] elig;

  assign elig  = eligible_set(req, mask, svc, smm);
  assign any   = |elig;
  assign level = first_set(elig);

  always_comb begin
    word = '0;
    if (any) begin
      word[DW-1]      = 1'b1;
      word[LVL_W-1:0] = level;
    end
  end

endmodule

// File: rtl/pic_host_port.sv
module pic_host_port
  import pic_rd_pkg::*;
#(
  parameter int N     = 8,
  parameter int DW    = 8,
  parameter int LVL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             wr,
  input  logic             rd,
  input  logic             a0,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [N-1:0]     req_bits,
  input  logic [N-1:0]     svc_bits,
  output logic [N-1:0]     mask_bits,
  output logic             smm_active,
  output logic             poll_freeze,
  output logic             poll_ack,
  output logic [LVL_W-1:0] poll_level
);

  logic             mask_wr;
  logic             cmd_wr;
  cmd_fields_t      fields;
  logic [DW-1:0]    mask_q;
  logic             smm_q;
  rd_sel_e          sel_q;
  logic             armed_q;
  logic             rd_act;
  logic             poll_rd;
  logic             win_any;
  logic [LVL_W-1:0] win_lvl;
  logic [DW-1:0]    poll_word;
  logic [DW-1:0]    stat_word;

  pic_cmd_decode #(.DW(DW)) u_dec (
    .cs      (cs),
    .wr      (wr),
    .a0      (a0),
    .wdata   (wdata),
    .mask_wr (mask_wr),
    .cmd_wr  (cmd_wr),
    .fields  (fields)
  );

  pic_mode_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_wr (mask_wr),
    .cmd_wr  (cmd_wr),
    .poll_rd (poll_rd),
    .fields  (fields),
    .wdata   (wdata),
    .mask_q  (mask_q),
    .smm_q   (smm_q),
    .sel_q   (sel_q),
    .armed_q (armed_q)
  );

  pic_poll_resolve #(.N(N), .DW(DW), .LVL_W(LVL_W)) u_res (
    .req   (req_bits),
    .mask  (mask_q[N-1:0]),
    .svc   (svc_bits),
    .smm   (smm_q),
    .any   (win_any),
    .level (win_lvl),
    .word  (poll_word)
  );

  assign rd_act  = cs & rd;
  assign poll_rd = rd_act & armed_q;

  always_comb begin
    stat_word = '0;
    if (a0) begin
      stat_word = mask_q;
    end else if (sel_q == SEL_SVC) begin
      stat_word[N-1:0] = svc_bits;
    end else begin
      stat_word[N-1:0] = req_bits;
    end
  end

  assign rdata       = !rd_act ? '0 : (armed_q ? poll_word : stat_word);
  assign mask_bits   = mask_q[N-1:0];
  assign smm_active  = smm_q;
  assign poll_freeze = armed_q;
  assign poll_ack    = poll_rd & win_any;
  assign poll_level  = poll_ack ? win_lvl : '0;

endmodule

// File: rtl/pic_host_port_chk.sv
module pic_host_port_chk #(
  parameter int N     = 8,
  parameter int DW    = 8,
  parameter int LVL_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             wr,
  input logic             rd,
  input logic             a0,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [N-1:0]     mask_bits,
  input logic             smm_active,
  input logic             poll_freeze,
  input logic             poll_ack,
  input logic [LVL_W-1:0] poll_level,
  input logic             cmd_wr,
  input logic             poll_rd
);

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && a0) |=> (mask_bits == $past(wdata[N-1:0])));

  assert_smm_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[6]) |=> (smm_active == $past(wdata[5])));

  assert_smm_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr || !wdata[6]) |=> $stable(smm_active));

  assert_freeze_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !a0 && wdata[4:3] == 2'b01 && wdata[2]) |=> poll_freeze);

  assert_freeze_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !wr) |=> !poll_freeze);

  assert_poll_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd |-> (rdata[DW-2:LVL_W] == '0));

  assert_poll_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd |-> (rdata[DW-1] == poll_ack));

  assert_ack_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> (cs && rd && poll_freeze));

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |=> !poll_ack);

  assert_level_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_ack |-> (poll_level == '0));

  assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> (rdata == '0));

endmodule

bind pic_host_port pic_host_port_chk #(.N(N), .DW(DW), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs          (cs),
  .wr          (wr),
  .rd          (rd),
  .a0          (a0),
  .wdata       (wdata),
  .rdata       (rdata),
  .mask_bits   (mask_bits),
  .smm_active  (smm_active),
  .poll_freeze (poll_freeze),
  .poll_ack    (poll_ack),
  .poll_level  (poll_level),
  .cmd_wr      (cmd_wr),
  .poll_rd     (poll_rd)
);

// File: tb/sim_pic_host_port.sv
module sim_pic_host_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, rd = 1'b0, a0 = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] req_bits = '0, svc_bits = '0;
  logic [7:0] mask_bits;
  logic       smm_active, poll_freeze, poll_ack;
  logic [2:0] poll_level;

  int n_cmp = 0;
  int n_bad = 0;

  // Bench model of the host-visible state.
  logic [7:0] m_mask = '0;
  logic       m_smm = 1'b0;
  logic       m_svc_sel = 1'b0;
  logic       m_armed = 1'b0;

  always #4 clk = ~clk;

  pic_host_port u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .a0(a0),
    .wdata(wdata), .rdata(rdata), .req_bits(req_bits), .svc_bits(svc_bits),
    .mask_bits(mask_bits), .smm_active(smm_active), .poll_freeze(poll_freeze),
    .poll_ack(poll_ack), .poll_level(poll_level)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Poll byte restated from the priority rules: scan from level 0 upward.
  function automatic logic [7:0] ref_poll(input logic [7:0] r, input logic [7:0] m,
                                          input logic [7:0] s, input logic sp);
    for (int i = 0; i < 8; i++) begin
      logic ok;
      ok = r[i] && !m[i];
      if (sp) begin
        ok = ok && !s[i];
      end else begin
        for (int j = 0; j <= i; j++) if (s[j]) ok = 1'b0;
      end
      if (ok) return 8'h80 | 8'(i);
    end
    return 8'h00;
  endfunction

  task automatic do_write(input logic addr, input logic [7:0] d);
    @(negedge clk);
    chk("R12", "idle rdata", 32'(rdata), 32'h0);
    cs = 1'b1; wr = 1'b1; a0 = addr; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    if (addr) begin
      m_mask = d;
    end else if (d[4:3] == 2'b01) begin
      if (d[6]) m_smm = d[5];
      if (d[1]) m_svc_sel = d[0];
      if (d[2]) m_armed = 1'b1;
    end
    #1;
    chk("R2", "mask_bits", 32'(mask_bits), 32'(m_mask));
    chk("R4", "smm_active", 32'(smm_active), 32'(m_smm));
    chk("R7", "poll_freeze", 32'(poll_freeze), 32'(m_armed));
  endtask

  task automatic do_read(input logic addr);
    logic [7:0] exp;
    logic [7:0] pw;
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; a0 = addr;
    #2;
    if (m_armed) begin
      pw = ref_poll(req_bits, m_mask, svc_bits, m_smm);
      chk("R8 R9", "poll byte", 32'(rdata), 32'(pw));
      chk("R10", "poll_ack", 32'(poll_ack), 32'(pw[7]));
      chk("R10", "poll_level", 32'(poll_level), 32'(pw[7] ? pw[2:0] : 3'd0));
    end else begin
      exp = addr ? m_mask : (m_svc_sel ? svc_bits : req_bits);
      chk("R5 R6 R11", "status read", 32'(rdata), 32'(exp));
      chk("R10", "no ack", 32'(poll_ack), 32'h0);
    end
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    m_armed = 1'b0;
    #1;
    chk("R11", "freeze after read", 32'(poll_freeze), 32'h0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "mask reset", 32'(mask_bits), 32'h0);
    chk("R1", "smm reset", 32'(smm_active), 32'h0);
    chk("R1", "freeze reset", 32'(poll_freeze), 32'h0);
    req_bits = 8'h5A; svc_bits = 8'hC3;
    do_read(1'b0);                       // R1: request bits by default

    // R3: non-command even writes leave everything alone
    do_write(1'b0, 8'h67);               // bit3 = 0
    do_write(1'b0, 8'h7F);               // bit4 = 1
    do_read(1'b0);

    // R5/R6: select in-service, read twice, mask write between
    do_write(1'b0, 8'h0B);
    do_read(1'b0);
    do_write(1'b1, 8'h81);
    do_read(1'b0);
    do_read(1'b1);                       // R2

    // R8: nothing eligible gives 0x00
    req_bits = 8'h00; svc_bits = 8'h00;
    do_write(1'b0, 8'h0C);
    do_read(1'b0);

    // R9: normal mode, level 2 in service blocks levels 2 and below
    do_write(1'b1, 8'h00);
    req_bits = 8'h34; svc_bits = 8'h04;
    do_write(1'b0, 8'h0C);
    do_read(1'b0);
    req_bits = 8'h36;
    do_write(1'b0, 8'h0C);
    do_read(1'b1);                       // poll wins over a0
    do_read(1'b0);                       // R11: back to status selection

    // R9: special mask mode lets lower levels through
    do_write(1'b0, 8'h68);
    req_bits = 8'h34; svc_bits = 8'h04;
    do_write(1'b0, 8'h0C);
    do_read(1'b0);
    do_write(1'b0, 8'h48);               // R4: clear special mask mode
    do_write(1'b0, 8'h28);               // R4: esmm=0 leaves it off

    for (int k = 0; k < 600; k++) begin
      logic [31:0] op;
      logic [7:0]  d;
      op = $urandom_range(0, 5);
      d  = 8'($urandom);
      req_bits = 8'($urandom);
      svc_bits = 8'($urandom) & 8'($urandom);
      case (op)
        0: do_write(1'b1, 8'($urandom) & 8'($urandom));
        1, 2: do_write(1'b0, (d & 8'hE7) | 8'h08);
        3: do_write(1'b0, d);
        default: do_read(1'($urandom));
      endcase
    end

    @(negedge clk);
    chk("R12", "final idle", 32'(rdata), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule